// File: doc/BRIEF.md
# Variable-Length Unit-Mask Bundle Unpacker

The block sits in front of a deep, barrel-style execution pipeline that is built from twelve sub-pipelines. Any of these can be switched on or off for each instruction. Instructions arrive as bundles on a 32-bit word stream with a valid/ready handshake. The first word of every bundle is a control word. It gives the bundle length and one enable bit per unit. The words after it carry only the fields of the enabled units, packed with no gaps in pipeline order and padded up to a whole word.

Field positions therefore move from one bundle to the next. The block stores the payload words, computes each unit's bit offset as a prefix sum of the widths of the enabled units before it, and extracts every field even when that field crosses a word boundary. All fields are presented at once with the unit mask and per-unit valid flags. The declared length is checked against the length implied by the mask. A bundle whose length does not match is dropped, and a one-cycle error pulse is raised.

Top module: `bundle_unpacker`

## Requirements
- R1: Control word layout: bits [4:0] give the total bundle length in words, control word included. Bits [16:5] are the unit enables, with bit 5+u enabling unit u. Units are numbered 0 to 11 in pipeline order: varying fetch, texture fetch, uniform/temp fetch, scalar multiply, vector multiply, scalar add, vector add, complex/LUT, framebuffer read/temp write, branch, then two further units. `unit_mask_o` bit u reports the enable of unit u.
- R2: Enabled fields are packed starting at the least significant payload bit, in ascending unit order, with no gaps. Payload bit p is bit p%32 of payload word p/32. Default field widths per unit are 14,18,22,30,40,34,40,30,24,20,28,16. A field can span two or more words. Field u appears right-aligned in `field_o[u*40 +: 40]`.
- R3: A disabled unit has `field_vld_o[u]` low and a zero field.
- R4: `out_valid_o` rises in the cycle after the last word of a well-formed bundle is accepted. While it is high, `field_vld_o` equals the unit mask.
- R5: While `out_valid_o` is high and `out_ready_i` is low, the output and its fields stay unchanged, and `in_ready_o` stays low throughout.
- R6: The expected length is 1 + ceil(sum of enabled widths / 32). If the declared length differs from it, `len_err_o` pulses for one cycle in the cycle after the control word is accepted. The next length−1 words are then consumed and dropped, and no output is produced.
- R7: A control word with an empty mask and a length of 1 is a complete bundle. Its output (all fields invalid) appears in the cycle after that word.
- R8: After a bundle completes or is dropped, the next accepted word is decoded as a control word.
- R9: After reset, `out_valid_o` and `len_err_o` are low and `in_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Input word valid |
| in_data_i | input | 32 | Input word |
| in_ready_o | output | 1 | Input word accepted when high with valid |
| out_valid_o | output | 1 | Decoded bundle available |
| out_ready_i | input | 1 | Consumer takes the decoded bundle |
| unit_mask_o | output | 12 | Enable mask of the decoded bundle |
| field_vld_o | output | 12 | Per-unit field valid |
| field_o | output | 480 | Per-unit fields, 40 bits per unit slot |
| len_err_o | output | 1 | One-cycle pulse on a length mismatch |

## Verification
The bench goes after fields that straddle one or more word boundaries under every mask shape: the empty mask, the full mask and a lone last unit. A design with a wrong prefix sum shifts every later field and corrupts it. A design with a wrong word index garbles the straddling bits. Length mismatches, both too short and too long and including a zero length, are followed at once by a good bundle. A design that drops the wrong number of words then decodes payload as a control word, and the expected sequence of outputs and error pulses diverges. The consumer stalls at random. A design that lets input in during a stall, or that changes fields while they are held, is caught by the hold and ready checks.

// File: rtl/bundle_unpack_pkg.sv
package bundle_unpack_pkg;
  localparam int unsigned NUM_UNITS = 12;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned LEN_W     = 5;

  typedef int unsigned width_tbl_t [NUM_UNITS];

  localparam width_tbl_t UNIT_W_DEF = '{14, 18, 22, 30, 40, 34, 40, 30, 24, 20, 28, 16};

  function automatic int unsigned tbl_sum(width_tbl_t t);
    int unsigned s = 0;
    for (int i = 0; i < NUM_UNITS; i++) s += t[i];
    return s;
  endfunction

  function automatic int unsigned tbl_max(width_tbl_t t);
    int unsigned m = 1;
    for (int i = 0; i < NUM_UNITS; i++) if (t[i] > m) m = t[i];
    return m;
  endfunction

  typedef enum logic [1:0] {
    ST_CTRL = 2'd0,
    ST_LOAD = 2'd1,
    ST_DROP = 2'd2
  } bu_state_e;
endpackage

// File: rtl/bu_offsets.sv
// Prefix sum of enabled field widths: bit offset of each unit and the total.
module bu_offsets
  import bundle_unpack_pkg::*;
#(
  parameter width_tbl_t  FIELD_W = UNIT_W_DEF,
  parameter int unsigned OFF_W   = 9
) (
  input  logic [NUM_UNITS-1:0]       en_i,
  output logic [NUM_UNITS*OFF_W-1:0] off_o,
  output logic [OFF_W-1:0]           total_o
);
  logic [(NUM_UNITS+1)*OFF_W-1:0] acc;

  assign acc[OFF_W-1:0] = '0;

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    localparam logic [OFF_W-1:0] W = OFF_W'(FIELD_W[u]);
    assign acc[(u+1)*OFF_W +: OFF_W] = acc[u*OFF_W +: OFF_W] + (en_i[u] ? W : '0);
    assign off_o[u*OFF_W +: OFF_W]   = acc[u*OFF_W +: OFF_W];
  end

  assign total_o = acc[NUM_UNITS*OFF_W +: OFF_W];
endmodule

// File: rtl/bu_extract.sv
// One shifter per unit pulls its field out of the payload buffer.
module bu_extract
  import bundle_unpack_pkg::*;
#(
  parameter width_tbl_t  FIELD_W = UNIT_W_DEF,
  parameter int unsigned OFF_W   = 9,
  parameter int unsigned BUF_W   = 320,
  parameter int unsigned FW_MAX  = 40
) (
  input  logic [BUF_W-1:0]            buf_i,
  input  logic [NUM_UNITS*OFF_W-1:0]  off_i,
  input  logic [NUM_UNITS-1:0]        en_i,
  output logic [NUM_UNITS*FW_MAX-1:0] field_o
);
  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    localparam logic [FW_MAX-1:0] KEEP = {FW_MAX{1'b1}} >> (FW_MAX - FIELD_W[u]);
    logic [BUF_W-1:0] shifted;
    assign shifted = buf_i >> off_i[u*OFF_W +: OFF_W];
    assign field_o[u*FW_MAX +: FW_MAX] = en_i[u] ? (shifted[FW_MAX-1:0] & KEEP) : '0;
  end
endmodule

// File: rtl/bu_collect.sv
// Word sequencer: control decode, length check, payload capture, drop, output hold.
module bu_collect
  import bundle_unpack_pkg::*;
#(
  parameter int unsigned OFF_W     = 9,
  parameter int unsigned MAX_WORDS = 10,
  localparam int unsigned BUF_W    = MAX_WORDS * WORD_W,
  localparam int unsigned IDX_W    = $clog2(MAX_WORDS + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 in_valid_i,
  input  logic [WORD_W-1:0]    in_data_i,
  output logic                 in_ready_o,
  input  logic                 out_ready_i,
  input  logic [OFF_W-1:0]     ctrl_bits_i,
  output logic [NUM_UNITS-1:0] ctrl_mask_o,
  output logic [NUM_UNITS-1:0] mask_o,
  output logic [BUF_W-1:0]     buf_o,
  output logic                 out_valid_o,
  output logic                 err_o
);
  localparam int unsigned CW = OFF_W + 1;

  bu_state_e            st_q;
  logic [LEN_W-1:0]     rem_q;
  logic [IDX_W-1:0]     idx_q;
  logic [BUF_W-1:0]     buf_q;
  logic [NUM_UNITS-1:0] mask_q;
  logic                 vld_q, err_q;

  logic [LEN_W-1:0] c_len;
  logic [CW-1:0]    need_bits, exp_len;
  logic             len_ok, accept;
  logic             unused_hi;

  assign c_len       = in_data_i[LEN_W-1:0];
  assign ctrl_mask_o = in_data_i[LEN_W +: NUM_UNITS];
  assign unused_hi   = ^in_data_i[WORD_W-1:LEN_W+NUM_UNITS];

  // words needed = 1 + ceil(bits / WORD_W)
  assign need_bits = {1'b0, ctrl_bits_i} + CW'(WORD_W - 1);
  assign exp_len   = (need_bits >> $clog2(WORD_W)) + CW'(1);
  assign len_ok    = (exp_len == CW'(c_len));

  assign in_ready_o = !vld_q;
  assign accept     = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_CTRL;
      rem_q  <= '0;
      idx_q  <= '0;
      buf_q  <= '0;
      mask_q <= '0;
      vld_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      err_q <= 1'b0;
      if (vld_q && out_ready_i) vld_q <= 1'b0;
      if (accept) begin
        unique case (st_q)
          ST_CTRL: begin
            idx_q <= '0;
            rem_q <= c_len - LEN_W'(1);
            if (!len_ok) begin
              err_q <= 1'b1;
              if (c_len > LEN_W'(1)) st_q <= ST_DROP;
            end else begin
              mask_q <= ctrl_mask_o;
              if (c_len == LEN_W'(1)) vld_q <= 1'b1;
              else                    st_q  <= ST_LOAD;
            end
          end
          ST_LOAD: begin
            for (int w = 0; w < MAX_WORDS; w++)
              if (idx_q == IDX_W'(w)) buf_q[w*WORD_W +: WORD_W] <= in_data_i;
            idx_q <= idx_q + IDX_W'(1);
            rem_q <= rem_q - LEN_W'(1);
            if (rem_q == LEN_W'(1)) begin
              vld_q <= 1'b1;
              st_q  <= ST_CTRL;
            end
          end
          ST_DROP: begin
            rem_q <= rem_q - LEN_W'(1);
            if (rem_q == LEN_W'(1)) st_q <= ST_CTRL;
          end
          default: st_q <= ST_CTRL;
        endcase
      end
    end
  end

  assign mask_o      = mask_q;
  assign buf_o       = buf_q;
  assign out_valid_o = vld_q;
  assign err_o       = err_q;
endmodule

// File: rtl/bundle_unpacker.sv
module bundle_unpacker
  import bundle_unpack_pkg::*;
#(
  parameter width_tbl_t FIELD_W = UNIT_W_DEF,
  localparam int unsigned SUM_W     = tbl_sum(FIELD_W),
  localparam int unsigned FW_MAX    = tbl_max(FIELD_W),
  localparam int unsigned MAX_WORDS = (SUM_W + WORD_W - 1) / WORD_W,
  localparam int unsigned BUF_W     = MAX_WORDS * WORD_W,
  localparam int unsigned OFF_W     = $clog2(SUM_W + 1)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        in_valid_i,
  input  logic [WORD_W-1:0]           in_data_i,
  output logic                        in_ready_o,
  output logic                        out_valid_o,
  input  logic                        out_ready_i,
  output logic [NUM_UNITS-1:0]        unit_mask_o,
  output logic [NUM_UNITS-1:0]        field_vld_o,
  output logic [NUM_UNITS*FW_MAX-1:0] field_o,
  output logic                        len_err_o
);
  logic [NUM_UNITS-1:0]       ctrl_mask, mask;
  logic [OFF_W-1:0]           ctrl_bits, held_bits;
  logic [NUM_UNITS*OFF_W-1:0] ctrl_off, held_off;
  logic [BUF_W-1:0]           payload;
  logic                       unused_off;

  assign unused_off = ^{ctrl_off, held_bits};

  // length check on the arriving control word
  bu_offsets #(.FIELD_W(FIELD_W), .OFF_W(OFF_W)) i_ctrl_off (
    .en_i   (ctrl_mask),
    .off_o  (ctrl_off),
    .total_o(ctrl_bits)
  );

  // field placement for the held bundle
  bu_offsets #(.FIELD_W(FIELD_W), .OFF_W(OFF_W)) i_held_off (
    .en_i   (mask),
    .off_o  (held_off),
    .total_o(held_bits)
  );

  bu_collect #(.OFF_W(OFF_W), .MAX_WORDS(MAX_WORDS)) i_collect (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (in_valid_i),
    .in_data_i  (in_data_i),
    .in_ready_o (in_ready_o),
    .out_ready_i(out_ready_i),
    .ctrl_bits_i(ctrl_bits),
    .ctrl_mask_o(ctrl_mask),
    .mask_o     (mask),
    .buf_o      (payload),
    .out_valid_o(out_valid_o),
    .err_o      (len_err_o)
  );

  bu_extract #(.FIELD_W(FIELD_W), .OFF_W(OFF_W), .BUF_W(BUF_W), .FW_MAX(FW_MAX)) i_extract (
    .buf_i  (payload),
    .off_i  (held_off),
    .en_i   (mask),
    .field_o(field_o)
  );

  assign unit_mask_o = mask;
  assign field_vld_o = out_valid_o ? mask : '0;
endmodule

// File: rtl/bundle_unpacker_chk.sv
module bundle_unpacker_chk
  import bundle_unpack_pkg::*;
#(
  parameter int unsigned FW_MAX = tbl_max(UNIT_W_DEF)
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        in_valid_i,
  input logic                        in_ready_o,
  input logic                        out_valid_o,
  input logic                        out_ready_i,
  input logic [NUM_UNITS-1:0]        unit_mask_o,
  input logic [NUM_UNITS-1:0]        field_vld_o,
  input logic [NUM_UNITS*FW_MAX-1:0] field_o,
  input logic                        len_err_o
);
  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(field_o) && $stable(unit_mask_o));

  assert_stall_ready_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !in_ready_o);

  assert_err_no_out_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    len_err_o |-> !out_valid_o);

  assert_out_after_word_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_valid_o) |-> $past(in_valid_i && in_ready_o));

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    assert_off_field_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_valid_o && !field_vld_o[u] |-> field_o[u*FW_MAX +: FW_MAX] == '0);
  end
endmodule

bind bundle_unpacker bundle_unpacker_chk #(.FW_MAX(FW_MAX)) i_chk (.*);

// File: tb/test_bundle_unpacker.sv
module test_bundle_unpacker;
  localparam int CLK_PERIOD = 10;
  localparam int NU = 12;
  localparam int FW = 40;
  localparam int unsigned BW [NU] = '{14, 18, 22, 30, 40, 34, 40, 30, 24, 20, 28, 16};

  typedef struct packed {
    logic              is_err;
    logic [NU-1:0]     mask;
    logic [NU*FW-1:0]  fields;
  } exp_t;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, out_ready = 0;
  logic [31:0] in_data = '0;
  logic in_ready, out_valid, len_err;
  logic [NU-1:0] unit_mask, field_vld;
  logic [NU*FW-1:0] field;

  int checks = 0, errors = 0;
  bit mon_on = 0, hold_prev = 0;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  bundle_unpacker i_bundle_unpacker (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_data_i(in_data),
    .in_ready_o(in_ready), .out_valid_o(out_valid), .out_ready_i(out_ready),
    .unit_mask_o(unit_mask), .field_vld_o(field_vld), .field_o(field),
    .len_err_o(len_err)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic send_word(input logic [31:0] w);
    bit rdy;
    @(negedge clk);
    while ($urandom % 4 == 0) begin
      in_valid = 0;
      @(negedge clk);
    end
    in_valid = 1;
    in_data  = w;
    forever begin
      rdy = in_ready;
      @(posedge clk);
      if (rdy) break;
      @(negedge clk);
    end
  endtask

  // force_len < 0: correct length; otherwise that length is declared (R6 when it differs)
  task automatic send_bundle(input logic [NU-1:0] mask, input logic [NU*FW-1:0] vals, input int force_len);
    logic [1023:0] p = '0;
    int pos = 0, nw, len;
    exp_t e;
    e.is_err = 0;
    e.mask   = mask;
    e.fields = '0;
    for (int u = 0; u < NU; u++) begin
      if (mask[u]) begin
        for (int b = 0; b < int'(BW[u]); b++) begin
          p[pos+b] = vals[u*FW+b];
          e.fields[u*FW+b] = vals[u*FW+b];
        end
        pos += int'(BW[u]);
      end
    end
    nw  = (pos + 31) / 32;
    len = 1 + nw;
    if (force_len >= 0 && force_len != len) begin
      e.is_err = 1;
      q.push_back(e);
      send_word({15'd0, mask, 5'(force_len)});
      for (int i = 1; i < force_len; i++) send_word($urandom);
    end else begin
      q.push_back(e);
      send_word({15'd0, mask, 5'(len)});
      for (int i = 0; i < nw; i++) send_word(p[i*32 +: 32]);
    end
  endtask

  function automatic logic [NU*FW-1:0] rand_vals();
    logic [NU*FW-1:0] v;
    for (int u = 0; u < NU; u++) v[u*FW +: FW] = FW'({$urandom, $urandom});
    return v;
  endfunction

  function automatic int good_len(input logic [NU-1:0] mask);
    int s = 0;
    for (int u = 0; u < NU; u++) if (mask[u]) s += int'(BW[u]);
    return 1 + (s + 31) / 32;
  endfunction

  always @(negedge clk) begin
    if (mon_on) begin
      if (hold_prev) chk(out_valid === 1'b1, "R5 output held under stall", 64'(out_valid), 1);
      hold_prev = 0;
      if (len_err) begin
        if (q.size() == 0) chk(0, "R6 unexpected error pulse", 1, 0);
        else begin
          chk(q[0].is_err, "R6 R8 error pulse instead of output", 1, 64'(q[0].is_err));
          void'(q.pop_front());
        end
      end
      if (out_valid) begin
        chk(!in_ready, "R5 ready low while output pending", 64'(in_ready), 0);
        if ($urandom % 4 != 0) begin
          exp_t e;
          out_ready = 1;
          if (q.size() == 0) chk(0, "R4 unexpected output", 1, 0);
          else begin
            e = q.pop_front();
            chk(!e.is_err, "R6 R8 output for discarded bundle", 1, 0);
            if (!e.is_err) begin
              if (e.mask == '0) chk(unit_mask == e.mask && field_vld == '0, "R7 empty bundle", 64'(unit_mask), 0);
              else chk(unit_mask == e.mask, "R1 unit mask", 64'(unit_mask), 64'(e.mask));
              chk(field_vld == e.mask, "R4 field valid", 64'(field_vld), 64'(e.mask));
              for (int u = 0; u < NU; u++) begin
                if (e.mask[u])
                  chk(field[u*FW +: FW] == e.fields[u*FW +: FW], $sformatf("R2 field unit %0d", u),
                      64'(field[u*FW +: FW]), 64'(e.fields[u*FW +: FW]));
                else
                  chk(!field_vld[u] && field[u*FW +: FW] == '0, $sformatf("R3 disabled unit %0d", u),
                      64'(field[u*FW +: FW]), 0);
              end
            end
          end
        end else begin
          out_ready = 0;
          hold_prev = 1;
        end
      end else out_ready = 1'($urandom % 2);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "R4 watchdog expired", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(out_valid == 0, "R9 out_valid after reset", 64'(out_valid), 0);
    chk(len_err == 0, "R9 len_err after reset", 64'(len_err), 0);
    chk(in_ready == 1, "R9 in_ready after reset", 64'(in_ready), 1);
    mon_on = 1;

    send_bundle('0, rand_vals(), -1);             // R7
    send_bundle('1, rand_vals(), -1);             // R2 all fields, many straddles
    send_bundle(12'h800, rand_vals(), -1);        // lone last unit
    send_bundle(12'h0a5, rand_vals(), -1);
    send_bundle('0, rand_vals(), 2);              // R6 too long, one word dropped
    send_bundle(12'h111, rand_vals(), -1);        // R8 resync
    send_bundle(12'h3ff, rand_vals(), 0);         // R6 zero length
    send_bundle(12'h3ff, rand_vals(), 3);         // R6 too short
    send_bundle(12'h3ff, rand_vals(), -1);        // R8
    send_bundle('1, rand_vals(), 31);             // R6 max length drop

    for (int n = 0; n < 250; n++) begin
      logic [NU-1:0] m = NU'($urandom);
      int fl = -1;
      if ($urandom % 6 == 0) begin
        fl = int'($urandom % 32);
        if (fl == good_len(m)) fl = (fl + 1) % 32;
      end
      send_bundle(m, rand_vals(), fl);
    end
    @(negedge clk);
    in_valid = 0;
    while (q.size() != 0 || out_valid) @(negedge clk);
    repeat (5) @(negedge clk);
    chk(q.size() == 0 && !out_valid && !len_err, "R4 all bundles delivered", 64'(q.size()), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule